// File: doc/BRIEF.md
# Vectored Edge Interrupt Controller

This block gathers eight interrupt sources and offers them to a processor core on three vectored request lines. Three sources are external pins: each is brought into the clock domain through a two-stage synchroniser and then edge-detected, and each pin has its own choice of rising or falling edge. The other five sources are single-cycle pulses from on-chip peripherals.

Every detected event sets a sticky pending flag. A pending flag whose per-source enable is set is a live request. A fixed table groups the sources onto the three vectors. Within a vector the lowest-numbered live source wins. Across vectors, vector 0 has the highest priority, and only one vector line is raised at a time, together with the vector number and the winning source number. The core pulses an acknowledge to clear the flag it is serving. Software can also clear flags by writing ones to them. A small register port gives access to the enable mask, the pin polarities, the pending flags and a global enable.

Top module: `vic_top`

## Requirements
- R1: After a clocked reset with rst_n low, the enable mask, pin polarities, pending flags and global enable all read 0, and irq_req is 0.
- R2: External pin k is source k (k = 0..2). Its polarity bit (register 1, bit k) selects the edge: 0 selects rising and 1 selects falling. An edge of the selected kind sets pending bit k within three clock edges. An edge of the other kind leaves the flag unchanged.
- R3: A one-cycle high on per_pulse[j] sets pending bit 3+j at the next clock edge.
- R4: A pending flag stays set until it is acknowledged or until a 1 is written to its bit of register 2. When a new event and a clear hit the same bit in the same cycle, the flag ends up set.
- R5: Sources 0 and 1 belong to vector 0, sources 2, 3 and 4 to vector 1, and sources 5, 6 and 7 to vector 2. A source counts as a request only when its bit in register 0 (the enable mask) is 1.
- R6: Within a vector, irq_src reports the lowest-numbered source that is both pending and enabled.
- R7: At most one bit of irq_req is high. The lowest-numbered vector that has a live source is presented, and irq_vec holds its number.
- R8: Bit 0 of register 3 is the global enable. When it is 0, irq_req is 0 and the pending flags are left as they were.
- R9: A cycle with irq_ack high while a request is shown clears exactly the pending flag of the source on irq_src.
- R10: reg_rdata returns register reg_addr combinationally: 0 is the enable mask, 1 the polarities in bits 2:0 (upper bits 0), 2 the pending flags whatever their enables, and 3 the global enable in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 3 | Asynchronous external interrupt pins |
| per_pulse | input | 5 | Single-cycle event pulses from peripherals |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_req | output | 3 | One-hot vector request lines |
| irq_vec | output | 2 | Number of the presented vector |
| irq_src | output | 3 | Number of the winning source |
| irq_ack | input | 1 | Acknowledge of the presented source |

## Verification
The first sweep fires every non-empty set of the eight sources with everything enabled. It separates the vector ordering from the ordering inside each vector and from the source-to-vector table. The second sweep holds all eight flags pending and walks all 256 enable masks, which shows that a disabled source can neither win nor hide a lower-priority one. An acknowledge run drains the flags one at a time, to show that only the presented flag clears. Directed cases cover the two pin polarities, a set and a clear landing on the same flag in the same cycle, and the global gate.

// File: rtl/vic_pkg.sv
// Package: shared sizes, register addresses and the fixed source-to-vector table.
// Assumes eight sources on three vectors; the group boundaries are constants here.
package vic_pkg;
    localparam int EXT_N    = 3;
    localparam int PER_N    = 5;
    localparam int SRC_N    = EXT_N + PER_N;
    localparam int VEC_N    = 3;
    localparam int SRC_W    = $clog2(SRC_N);
    localparam int VEC_W    = $clog2(VEC_N);
    localparam int SYNC_N   = 2;
    localparam int GRP0_TOP = 1;   // highest source number in vector 0
    localparam int GRP1_TOP = 4;   // highest source number in vector 1

    localparam logic [1:0] RA_ENABLE = 2'd0;
    localparam logic [1:0] RA_POLAR  = 2'd1;
    localparam logic [1:0] RA_PEND   = 2'd2;
    localparam logic [1:0] RA_CTRL   = 2'd3;

    // Vector that a given source belongs to
    function automatic int src_vec(input int s);
        if (s <= GRP0_TOP)      return 0;
        else if (s <= GRP1_TOP) return 1;
        else                    return 2;
    endfunction
endpackage

// File: rtl/vic_edge_det.sv
// Edge detector for one external pin. It synchronises the pin through STAGES
// flops, keeps one extra history flop, and pulses for one cycle on the edge
// chosen by fall_sel (0 rising, 1 falling). It assumes the pin is asynchronous
// and stays at each level for at least one clock period.
module vic_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic pulse
);
    logic [STAGES:0] shreg;
    logic            synced;
    logic            prev;

    // Shift the pin through the synchroniser and the history flop
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-1:0], pin};
    end

    assign synced = shreg[STAGES-1];
    assign prev   = shreg[STAGES];

    // Pick the edge of the programmed polarity
    always_comb begin
        if (fall_sel) pulse = prev & ~synced;
        else          pulse = synced & ~prev;
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (!pulse || !$stable(fall_sel))) else $error("edge pulse repeated"); // R2
endmodule

// File: rtl/vic_resolver.sv
// Priority resolver for one vector. From the live (pending and enabled) sources
// it keeps those that belong to vector VEC_IDX and reports the lowest-numbered
// one. It assumes live is already masked by the per-source enables.
module vic_resolver #(
    parameter  int SRC_N   = 8,
    parameter  int VEC_IDX = 0,
    localparam int SRC_W   = $clog2(SRC_N)
) (
    input  logic [SRC_N-1:0] live,
    output logic             hit,
    output logic [SRC_W-1:0] win
);
    logic [SRC_N-1:0] member;
    logic [SRC_N-1:0] cand;

    for (genvar g = 0; g < SRC_N; g++) begin : g_member
        assign member[g] = (vic_pkg::src_vec(g) == VEC_IDX);
    end

    assign cand = live & member;

    // Find the lowest-numbered candidate
    always_comb begin
        hit = |cand;
        win = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (cand[i]) win = SRC_W'(i);
        end
    end

    // Check that any winner is itself a live member of this vector
    always_comb begin
        if (hit) begin
            AST_WIN_IS_LIVE: assert (live[win] && member[win]) else $error("bad winner"); // R6
        end
    end
endmodule

// File: rtl/vic_top.sv
// Vectored edge interrupt controller. Three synchronised, edge-detected pins and
// five peripheral pulses set sticky pending flags. Enabled flags are resolved
// inside each vector, and the lowest live vector is presented. The register
// write port and the acknowledge clear flags, but a new event in the same cycle
// wins. It assumes peripheral pulses and irq_ack are synchronous to clk.
module vic_top
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXT_N-1:0] ext_pin,
    input  logic [PER_N-1:0] per_pulse,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [SRC_N-1:0] reg_wdata,
    output logic [SRC_N-1:0] reg_rdata,
    output logic [VEC_N-1:0] irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic [SRC_W-1:0] irq_src,
    input  logic             irq_ack
);
    logic [SRC_N-1:0] en_mask;
    logic [EXT_N-1:0] pol;
    logic [SRC_N-1:0] pending;
    logic             glb_en;

    logic [EXT_N-1:0] ext_edge;
    logic [SRC_N-1:0] set_vec;
    logic [SRC_N-1:0] clr_vec;
    logic [SRC_N-1:0] live;
    logic [VEC_N-1:0] vhit;
    logic [SRC_W-1:0] vwin [VEC_N];

    for (genvar k = 0; k < EXT_N; k++) begin : g_pin
        vic_edge_det #(.STAGES(SYNC_N)) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (ext_pin[k]),
            .fall_sel (pol[k]),
            .pulse    (ext_edge[k])
        );
    end

    assign set_vec = {per_pulse, ext_edge};
    assign live    = pending & en_mask;

    for (genvar v = 0; v < VEC_N; v++) begin : g_vec
        vic_resolver #(.SRC_N(SRC_N), .VEC_IDX(v)) u_res (
            .live (live),
            .hit  (vhit[v]),
            .win  (vwin[v])
        );
    end

    // Present the lowest-numbered vector that has a live source
    always_comb begin
        irq_req = '0;
        irq_vec = '0;
        irq_src = '0;
        for (int v = VEC_N - 1; v >= 0; v--) begin
            if (vhit[v]) begin
                irq_vec = VEC_W'(v);
                irq_src = vwin[v];
            end
        end
        if (glb_en && |vhit) irq_req[irq_vec] = 1'b1;
    end

    // Gather the flag clears from the acknowledge and from software writes
    always_comb begin
        clr_vec = '0;
        if (irq_ack && |irq_req)                clr_vec[irq_src] = 1'b1;
        if (reg_wr && reg_addr == RA_PEND)      clr_vec = clr_vec | reg_wdata;
    end

    // Update the pending flags; a new event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~clr_vec) | set_vec;
    end

    // Hold the configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_mask <= '0;
            pol     <= '0;
            glb_en  <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_ENABLE: en_mask <= reg_wdata;
                RA_POLAR:  pol     <= reg_wdata[EXT_N-1:0];
                RA_CTRL:   glb_en  <= reg_wdata[0];
                default:   ;
            endcase
        end
    end

    // Return the selected register
    always_comb begin
        case (reg_addr)
            RA_ENABLE: reg_rdata = en_mask;
            RA_POLAR:  reg_rdata = {{(SRC_N-EXT_N){1'b0}}, pol};
            RA_PEND:   reg_rdata = pending;
            default:   reg_rdata = {{(SRC_N-1){1'b0}}, glb_en};
        endcase
    end

    AST_ONE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_req)) else $error("several vectors"); // R7
    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> (irq_req == '0)) else $error("request while gated"); // R8
    AST_REQ_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |-> (pending[irq_src] && en_mask[irq_src])) else $error("request without source"); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && |irq_req && !set_vec[irq_src]) |=> !pending[$past(irq_src)]) else $error("ack kept flag"); // R9
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & $past(pending & ~clr_vec)) == $past(pending & ~clr_vec))) else $error("flag lost"); // R4
endmodule

// File: tb/tb_vic_top.sv
module tb_vic_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ext_pin = '0;
    logic [4:0] per_pulse = '0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] irq_req;
    logic [1:0] irq_vec;
    logic [2:0] irq_src;
    logic       irq_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vic_top dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .per_pulse(per_pulse),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_src(irq_src), .irq_ack(irq_ack)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    // Group of a source per R5
    function automatic int grp(input int s);
        return (s < 2) ? 0 : (s < 5) ? 1 : 2;
    endfunction

    // Expected winner per R6 and R7; returns -1 when none
    function automatic int winner(input int live);
        for (int v = 0; v < 3; v++)
            for (int s = 0; s < 8; s++)
                if (live[s] && grp(s) == v) return s;
        return -1;
    endfunction

    task automatic expect_irq(input string tag, input int live, input bit gate);
        int w;
        w = winner(live);
        if (!gate || w < 0) begin
            chk({tag, " req"}, int'(irq_req), 0);
        end else begin
            chk({tag, " req"}, int'(irq_req), 1 << grp(w));
            chk({tag, " vec"}, int'(irq_vec), grp(w));
            chk({tag, " src"}, int'(irq_src), w);
        end
    endtask

    // Raise the chosen sources: pins high for a while, pulses for one cycle
    task automatic fire(input logic [7:0] m);
        @(negedge clk);
        ext_pin = m[2:0]; per_pulse = m[7:3];
        @(negedge clk);
        per_pulse = '0;
        repeat (2) @(negedge clk);
        ext_pin = '0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg", v, 0);
        end
        chk("R1 req", int'(irq_req), 0);

        wr(2'd0, 8'hFF);
        wr(2'd3, 8'h01);
        rd(2'd0, v); chk("R10 enable read", v, 255);
        rd(2'd3, v); chk("R10 ctrl read", v, 1);

        // R5 R6 R7: every non-empty source set, all enabled, rising pins (R2 R3)
        for (int m = 1; m < 256; m++) begin
            fire(8'(m));
            rd(2'd2, v);
            chk("R2 R3 pending after events", v, m);
            expect_irq("R7 sweep", m, 1'b1);
            wr(2'd2, 8'hFF);
            rd(2'd2, v);
            chk("R4 w1c clears", v, 0);
        end

        // R5 R6: all flags pending, walk every enable mask
        fire(8'hFF);
        for (int e = 0; e < 256; e++) begin
            wr(2'd0, 8'(e));
            expect_irq("R5 enable sweep", e, 1'b1);
        end

        // R8: global gate holds requests off and keeps flags
        wr(2'd3, 8'h00);
        chk("R8 gated req", int'(irq_req), 0);
        rd(2'd2, v); chk("R8 flags kept", v, 255);
        wr(2'd3, 8'h01);
        expect_irq("R8 regated", 255, 1'b1);

        // R9: acknowledges drain flags in priority order
        for (int k = 0; k < 8; k++) begin
            chk("R9 src before ack", int'(irq_src), k);
            @(negedge clk); irq_ack = 1'b1;
            @(negedge clk); irq_ack = 1'b0;
            rd(2'd2, v);
            chk("R9 pending after ack", v, (255 << (k + 1)) & 255);
        end
        chk("R9 idle", int'(irq_req), 0);

        // R2: falling polarity ignores rise, catches fall
        wr(2'd1, 8'h07);
        rd(2'd1, v); chk("R10 polarity read", v, 7);
        @(negedge clk); ext_pin = 3'b111;
        repeat (5) @(negedge clk);
        rd(2'd2, v); chk("R2 rise ignored", v, 0);
        ext_pin = 3'b000;
        repeat (5) @(negedge clk);
        rd(2'd2, v); chk("R2 fall taken", v, 7);
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'h00);

        // R4: event and clear on the same flag in the same cycle
        @(negedge clk);
        per_pulse = 5'b00001; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h08;
        @(negedge clk);
        per_pulse = '0; reg_wr = 1'b0;
        rd(2'd2, v); chk("R4 set beats clear", v, 8);
        repeat (3) @(negedge clk);
        rd(2'd2, v); chk("R4 sticky", v, 8);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule